// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a watchdog timer controlled through a single 32-bit control register on a simple bus. The bus has a write strobe, a read strobe, an address and write/read data. A prescaler divides the clock into ticks, and a 2-bit divider code selects its ratio. An interval counter counts those ticks up to a limit chosen by a 2-bit interval code. When the interval expires, the block sets a sticky warning flag and can raise an interrupt. If software does not restart the count within a fixed grace window, the block pulses a reset request for a fixed number of clock cycles and sets a sticky reset flag.

Software keeps the system alive by kicking the watchdog: it reads the register and writes the value back with the restart bit set. Writing all zeros stops the watchdog. With the counter and reset stages enabled and the interrupt disabled, the block still issues a reset, so software can use it to force a restart. Reading the register shows whether the watchdog is enabled.

The control state machine has four states:
- `ST_OFF`: the counter is stopped.
- `ST_COUNT`: the interval is running.
- `ST_WARN`: the grace window after the warning is running.
- `ST_FIRE`: the reset pulse is being driven.

Its transitions are:
- `t_start`: `ST_OFF` to `ST_COUNT` when the enable bit is set.
- `t_expire`: `ST_COUNT` to `ST_WARN` on the last interval tick.
- `t_kick`: `ST_COUNT` or `ST_WARN` back to `ST_COUNT` on a restart.
- `t_grace_fire`: `ST_WARN` to `ST_FIRE` at the end of the grace window when the reset stage is enabled.
- `t_grace_rearm`: `ST_WARN` to `ST_COUNT` at the end of the grace window when the reset stage is disabled.
- `t_pulse_done`: `ST_FIRE` to `ST_COUNT` after the pulse.
- `t_stop`: any state to `ST_OFF` when the enable bit is clear.

A restart has no effect in `ST_FIRE`.

Top module: `wdt2s_top`

## Requirements
- R1: After reset the register reads 0x00000000, and `wdog_irq` and `sys_rst_req` are low.
- R2: Register layout:

  | Bits | Field |
  |------|-------|
  | 11:10 | divider code |
  | 7 | counter enable |
  | 6 | interrupt enable |
  | 5:4 | interval code |
  | 3 | warning flag |
  | 2 | reset flag |
  | 1 | reset enable |
  | 0 | restart |

  Bit 0 and the unused bits always read 0, and writing 1 to bit 3 or bit 2 never sets a flag. A write to any other address leaves the register unchanged, and a read at any other address returns 0.
- R3: The prescaler ratio R is PRE_LO for divider codes 00 and 01, PRE_MID for 10 and PRE_HI for 11. The interval limit L is BASE_TICKS·4^code. The warning flag sets, and `wdog_irq` rises if enabled, L·R clock edges after the count origin.
- R4: `wdog_irq` is high only while the warning flag and interrupt enable are both set. With the interrupt disabled the flag still sets and the reset stage still acts.
- R5: GRACE_TICKS·R edges after the warning, with reset enabled, `sys_rst_req` is high for exactly RST_PULSE cycles and the reset flag sets. Counting then resumes from zero.
- R6: With reset disabled, no pulse is issued at the end of the grace window and the reset flag stays clear. The count restarts from zero at that edge.
- R7: A write with bit 0 set while counting or warning makes that write edge the new count origin.
- R8: A write that changes the divider code or the interval code restarts the count at that write edge, even with bit 0 clear.
- R9: The flags stay set until a write with a 1 in their bit position. A flag set in the same cycle takes priority over the clear.
- R10: A write with the enable bit clear stops the watchdog, and both outputs stay low while it is stopped. When the watchdog is enabled from the stopped state, the count origin is the edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_rd` is high |
| wdog_irq | output | 1 | Early-warning interrupt, level |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The assertions assume that a change of divider code happens only through a register write. That write always restarts the prescaler, so the prescaler count never exceeds the new ratio. They also assume `rst_n` is released away from a clock edge and that the bus carries at most one access per cycle. The bench changes inputs one nanosecond after a rising edge and issues single-cycle writes only. It sweeps all sixteen divider and interval code pairs with small parameter values, so every limit and ratio combination is reached within a short run.

// File: rtl/wdt2s_pkg.sv
package wdt2s_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_WARN  = 2'd2,
        ST_FIRE  = 2'd3
    } wd_state_e;

    // Bit positions within the control word
    localparam int unsigned B_RESTART = 0;
    localparam int unsigned B_RST_EN  = 1;
    localparam int unsigned B_RFLAG   = 2;
    localparam int unsigned B_IFLAG   = 3;
    localparam int unsigned B_IVL_LO  = 4;
    localparam int unsigned B_IRQ_EN  = 6;
    localparam int unsigned B_EN      = 7;
    localparam int unsigned B_DIV_LO  = 10;

    typedef struct packed {
        logic [1:0] div;
        logic       en;
        logic       irq_en;
        logic [1:0] ivl;
        logic       irq_f;
        logic       rst_f;
        logic       rst_en;
    } ctrl_t;

endpackage

// File: rtl/wdt2s_prescale.sv
module wdt2s_prescale #(
    parameter int unsigned PRE_LO  = 16,
    parameter int unsigned PRE_MID = 128,
    parameter int unsigned PRE_HI  = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] div_sel,
    output logic       tick
);
    localparam int PW = $clog2(PRE_HI + 1);

    logic [PW-1:0] ratio;
    logic [PW-1:0] pcnt_q;

    always_comb begin
        unique case (div_sel)
            2'b10:   ratio = PW'(PRE_MID);
            2'b11:   ratio = PW'(PRE_HI);
            default: ratio = PW'(PRE_LO);
        endcase
    end

    assign tick = !clr && (pcnt_q >= ratio - PW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pcnt_q <= '0;
        else if (clr || tick)  pcnt_q <= '0;
        else                   pcnt_q <= pcnt_q + PW'(1);
    end

    // R3: a divider change always arrives with a clear, so the count stays in range
    assert_pcnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q < ratio);

endmodule

// File: rtl/wdt2s_ticks.sv
module wdt2s_ticks #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (clr)  count <= '0;
        else if (inc)  count <= count + CW'(1);
    end
endmodule

// File: rtl/wdt2s_fsm.sv
module wdt2s_fsm
    import wdt2s_pkg::*;
#(
    parameter int          CW          = 17,
    parameter int unsigned GRACE_TICKS = 1024,
    parameter int unsigned RST_PULSE   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rst_en,
    input  logic          kick,
    input  logic          tick,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] limit,
    output wd_state_e     state_o,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          pre_clr,
    output logic          warn_set,
    output logic          fire_set,
    output logic          sys_rst
);
    localparam int PCW = $clog2(RST_PULSE + 1);

    wd_state_e      state_q, state_d;
    logic [PCW-1:0] pc_q;
    logic           last_ivl, last_grace, pulse_done;

    assign last_ivl   = tick && (count == limit - CW'(1));
    assign last_grace = tick && (count == CW'(GRACE_TICKS - 1));
    assign pulse_done = (pc_q == PCW'(RST_PULSE - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en) state_d = ST_COUNT;                      // t_start
            ST_COUNT: begin
                if (kick)          state_d = ST_COUNT;                 // t_kick
                else if (last_ivl) state_d = ST_WARN;                  // t_expire
            end
            ST_WARN: begin
                if (kick)            state_d = ST_COUNT;               // t_kick
                else if (last_grace) state_d = rst_en ? ST_FIRE        // t_grace_fire
                                                      : ST_COUNT;      // t_grace_rearm
            end
            ST_FIRE:  if (pulse_done) state_d = ST_COUNT;              // t_pulse_done
        endcase
        if (!en) state_d = ST_OFF;                                     // t_stop
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Reset pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pc_q <= '0;
        else if (state_q != ST_FIRE) pc_q <= '0;
        else                        pc_q <= pc_q + PCW'(1);
    end

    // Outputs
    always_comb begin
        cnt_clr  = (state_q == ST_OFF) || (state_q == ST_FIRE) || kick || (state_d != state_q);
        cnt_inc  = tick && ((state_q == ST_COUNT) || (state_q == ST_WARN));
        pre_clr  = (state_q == ST_OFF) || (state_q == ST_FIRE) || kick;
        warn_set = (state_q == ST_COUNT) && (state_d == ST_WARN);
        fire_set = (state_q == ST_WARN)  && (state_d == ST_FIRE);
        sys_rst  = (state_q == ST_FIRE);
        state_o  = state_q;
    end

    // R5: the reset pulse is only ever entered from the grace window
    assert_fire_from_warn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE && $past(state_q) != ST_FIRE) |-> $past(state_q) == ST_WARN);

    // R5: a pulse that ends while enabled has lasted the full length
    assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sys_rst) && $past(en)) |-> $past(pc_q) == PCW'(RST_PULSE - 1));

endmodule

// File: rtl/wdt2s_top.sv
module wdt2s_top
    import wdt2s_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned REG_ADDR    = 0,
    parameter int unsigned PRE_LO      = 16,
    parameter int unsigned PRE_MID     = 128,
    parameter int unsigned PRE_HI      = 4096,
    parameter int unsigned BASE_TICKS  = 1024,
    parameter int unsigned GRACE_TICKS = 1024,
    parameter int unsigned RST_PULSE   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdog_irq,
    output logic              sys_rst_req
);
    localparam int CW = $clog2(BASE_TICKS * 64 + GRACE_TICKS + 1);

    ctrl_t         ctrl_q;
    wd_state_e     state;
    logic          wr_hit, rd_hit, kick;
    logic          tick, cnt_clr, cnt_inc, pre_clr, warn_set, fire_set;
    logic [CW-1:0] count, limit;
    logic          unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:12], bus_wdata[9:8]};

    assign wr_hit = bus_wr && (bus_addr == ADDR_W'(REG_ADDR));
    assign rd_hit = bus_rd && (bus_addr == ADDR_W'(REG_ADDR));
    assign kick   = wr_hit && (bus_wdata[B_RESTART]
                    || (bus_wdata[B_DIV_LO+1:B_DIV_LO] != ctrl_q.div)
                    || (bus_wdata[B_IVL_LO+1:B_IVL_LO] != ctrl_q.ivl));

    assign limit = CW'(BASE_TICKS) << {ctrl_q.ivl, 1'b0};

    // Control register with write-one-to-clear flags; a set wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_hit) begin
                ctrl_q.div    <= bus_wdata[B_DIV_LO+1:B_DIV_LO];
                ctrl_q.en     <= bus_wdata[B_EN];
                ctrl_q.irq_en <= bus_wdata[B_IRQ_EN];
                ctrl_q.ivl    <= bus_wdata[B_IVL_LO+1:B_IVL_LO];
                ctrl_q.rst_en <= bus_wdata[B_RST_EN];
                if (bus_wdata[B_IFLAG]) ctrl_q.irq_f <= 1'b0;
                if (bus_wdata[B_RFLAG]) ctrl_q.rst_f <= 1'b0;
            end
            if (warn_set) ctrl_q.irq_f <= 1'b1;
            if (fire_set) ctrl_q.rst_f <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata[B_DIV_LO+1:B_DIV_LO] = ctrl_q.div;
            bus_rdata[B_EN]                = ctrl_q.en;
            bus_rdata[B_IRQ_EN]            = ctrl_q.irq_en;
            bus_rdata[B_IVL_LO+1:B_IVL_LO] = ctrl_q.ivl;
            bus_rdata[B_IFLAG]             = ctrl_q.irq_f;
            bus_rdata[B_RFLAG]             = ctrl_q.rst_f;
            bus_rdata[B_RST_EN]            = ctrl_q.rst_en;
        end
    end

    assign wdog_irq = ctrl_q.irq_f && ctrl_q.irq_en;

    wdt2s_prescale #(
        .PRE_LO(PRE_LO), .PRE_MID(PRE_MID), .PRE_HI(PRE_HI)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(pre_clr), .div_sel(ctrl_q.div), .tick(tick)
    );

    wdt2s_ticks #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(count)
    );

    wdt2s_fsm #(
        .CW(CW), .GRACE_TICKS(GRACE_TICKS), .RST_PULSE(RST_PULSE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .rst_en(ctrl_q.rst_en),
        .kick(kick), .tick(tick), .count(count), .limit(limit),
        .state_o(state), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .pre_clr(pre_clr),
        .warn_set(warn_set), .fire_set(fire_set), .sys_rst(sys_rst_req)
    );

    // R3: the warning flag only rises as the grace window begins
    assert_warn_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.irq_f) |-> state == ST_WARN);

    // R5: the reset flag is set together with the start of the pulse
    assert_rst_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req) |-> ctrl_q.rst_f);

    // R7: a restart while running leaves the tick count at zero
    assert_kick_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && (state == ST_COUNT || state == ST_WARN)) |=> count == '0);

    // R10: a cleared enable stops the machine and silences the reset request
    assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |=> (state == ST_OFF && !sys_rst_req));

endmodule

// File: tb/wdt2s_top_tb_top.sv
`timescale 1ns/100ps
module wdt2s_top_tb_top;
    localparam int PRE_LO = 2, PRE_MID = 3, PRE_HI = 5;
    localparam int BASE = 2, GRACE = 3, PULSE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_irq, sys_rst_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wdt2s_top #(
        .ADDR_W(8), .REG_ADDR(0), .PRE_LO(PRE_LO), .PRE_MID(PRE_MID), .PRE_HI(PRE_HI),
        .BASE_TICKS(BASE), .GRACE_TICKS(GRACE), .RST_PULSE(PULSE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_irq(wdog_irq),
        .sys_rst_req(sys_rst_req)
    );

    function automatic int ratio(int d);
        return (d == 2) ? PRE_MID : (d == 3) ? PRE_HI : PRE_LO;
    endfunction

    function automatic int lim(int v);
        return BASE << (2 * v);
    endfunction

    function automatic logic [31:0] mk(int d, int v, int en, int ie, int re, int k);
        return 32'((d << 10) | (en << 7) | (ie << 6) | (v << 4) | (re << 1) | k);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_wdata = '0; bus_addr = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #0.5;
        d = bus_rdata;
        bus_rd = 1'b0; bus_addr = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        rd(8'h00, r); chk("R1 register", r, 32'h0);
        chk("R1 irq", 32'(wdog_irq), 0);
        chk("R1 sysrst", 32'(sys_rst_req), 0);

        // R2: layout, self-clearing restart bit, flags not settable, address decode
        wr(8'h00, 32'h0000_0CBF);
        rd(8'h00, r); chk("R2 readback", r, 32'h0000_0CB2);
        rd(8'h04, r); chk("R2 other address read", r, 32'h0);
        wr(8'h04, 32'h0);
        rd(8'h00, r); chk("R2 other address write", r, 32'h0000_0CB2);
        wr(8'h00, 32'h0000_000C);
        rd(8'h00, r); chk("R2 stopped", r, 32'h0);

        // R3/R5/R10: sweep all divider and interval codes
        for (int d = 0; d < 4; d++) begin
            for (int v = 0; v < 4; v++) begin
                int lr, gr;
                lr = ratio(d) * lim(v);
                gr = ratio(d) * GRACE;
                wr(8'h00, mk(d, v, 1, 1, 1, 1));
                step(lr);
                chk($sformatf("R3 irq early d%0d v%0d", d, v), 32'(wdog_irq), 0);
                step(1);
                chk($sformatf("R3 irq rise d%0d v%0d", d, v), 32'(wdog_irq), 1);
                step(gr - 1);
                chk($sformatf("R5 rst early d%0d v%0d", d, v), 32'(sys_rst_req), 0);
                step(1);
                chk($sformatf("R5 rst rise d%0d v%0d", d, v), 32'(sys_rst_req), 1);
                step(PULSE - 1);
                chk($sformatf("R5 rst hold d%0d v%0d", d, v), 32'(sys_rst_req), 1);
                step(1);
                chk($sformatf("R5 rst end d%0d v%0d", d, v), 32'(sys_rst_req), 0);
                rd(8'h00, r);
                chk($sformatf("R5 flags d%0d v%0d", d, v), r & 32'hC, 32'hC);
                wr(8'h00, 32'h0000_000C);
                chk($sformatf("R10 irq off d%0d v%0d", d, v), 32'(wdog_irq), 0);
            end
        end

        // R7: kick while counting and while warning
        wr(8'h00, 32'h0000_04D3);
        step(10);
        wr(8'h00, 32'h0000_04D3);
        step(15);
        chk("R7 kick delays warning", 32'(wdog_irq), 0);
        step(1);
        chk("R7 warning after kick", 32'(wdog_irq), 1);
        step(2);
        wr(8'h00, 32'h0000_04D3);
        step(3);
        chk("R7 kick in warn blocks reset", 32'(sys_rst_req), 0);
        rd(8'h00, r); chk("R9 flag sticky after kick", r & 32'h8, 32'h8);
        wr(8'h00, 32'h0000_04DB);
        chk("R9 flag cleared", 32'(wdog_irq), 0);
        step(15);
        chk("R7 no early warning", 32'(wdog_irq), 0);
        step(1);
        chk("R7 warning again", 32'(wdog_irq), 1);

        // R10: writing zero stops everything but keeps the sticky flag
        wr(8'h00, 32'h0);
        rd(8'h00, r); chk("R10 zero write readback", r, 32'h0000_0008);
        chk("R10 irq masked", 32'(wdog_irq), 0);
        step(300);
        chk("R10 no reset while stopped", 32'(sys_rst_req), 0);
        chk("R10 no irq while stopped", 32'(wdog_irq), 0);
        wr(8'h00, 32'h0000_000C);
        rd(8'h00, r); chk("R9 cleared by W1C", r, 32'h0);

        // R8: interval change restarts with bit 0 clear
        wr(8'h00, 32'h0000_04D2);
        step(10);
        wr(8'h00, 32'h0000_04C2);
        step(3);
        chk("R8 no early warning", 32'(wdog_irq), 0);
        step(1);
        chk("R8 warning at new limit", 32'(wdog_irq), 1);
        wr(8'h00, 32'h0000_000C);

        // R4: interrupt disabled, flag and reset still act
        wr(8'h00, 32'h0000_0483);
        step(5);
        chk("R4 irq pin masked", 32'(wdog_irq), 0);
        rd(8'h00, r); chk("R4 flag set while masked", r, 32'h0000_048A);
        step(5);
        chk("R4 rst early", 32'(sys_rst_req), 0);
        step(1);
        chk("R4 reset without irq", 32'(sys_rst_req), 1);
        step(PULSE);
        wr(8'h00, 32'h0000_000C);

        // R6: reset disabled, count restarts after grace
        wr(8'h00, 32'h0000_04C1);
        step(5);
        chk("R6 warning", 32'(wdog_irq), 1);
        step(6);
        chk("R6 no pulse", 32'(sys_rst_req), 0);
        rd(8'h00, r); chk("R6 reset flag clear", r & 32'h4, 32'h0);
        wr(8'h00, 32'h0000_04C8);
        chk("R9 clear without restart", 32'(wdog_irq), 0);
        step(2);
        chk("R6 rearm early", 32'(wdog_irq), 0);
        step(1);
        chk("R6 rearmed warning", 32'(wdog_irq), 1);
        wr(8'h00, 32'h0000_000C);

        finish_run();
    end
endmodule